// File: doc/BRIEF.md
# Multi-hart machine timer comparator

This block keeps one free-running 64-bit time value for a group of harts. Each hart has its own 64-bit compare register and its own level-sensitive timer interrupt line. The time value advances by one on every clock in which the timebase tick-enable input is high. Software reads and writes the time value and the compare registers over a simple register bus. The bus takes 4-byte and 8-byte accesses, little-endian, and a 4-byte access to one half of a 64-bit register leaves the other half unchanged.

A hart's interrupt line stays high for as long as its compare value is at or below the current time. One comparator runs continuously for each hart, so a write to the time value re-evaluates every hart with no extra sequencing. The compare region and the time register each start at their own parameterised offset. Every decoded access falls into one of five kinds: none, time low, time high, compare low and compare high. No multi-cycle state sequence exists. Each access completes in the cycle that presents it.

Top module: `mtimer_cmp`

## Requirements
- R1: The compare register of hart i sits at byte offset CMP_BASE + 8*i. A read at +0 returns the whole value when req_wide=1, or bits 31:0 in rd_data[31:0] with the upper half zero when req_wide=0. A read at +4 returns bits 63:32 in rd_data[31:0] with the upper half zero. Read data appears on rd_data in the cycle after the request. rd_data is zero after any cycle that carried no read.
- R2: irq[i] is high exactly when compare_i <= time, compared as unsigned 64-bit numbers. The output is registered: it reflects the register values from one clock earlier. This includes the equality case and the case where time holds all ones.
- R3: A 4-byte compare write (req_wide=0) takes its data from req_wdata[31:0]. At +0 it replaces bits 31:0 and at +4 it replaces bits 63:32, and in both cases the other half is kept. An 8-byte write at +0 replaces all 64 bits.
- R4: An 8-byte write at the +4 offset of a compare register, or at TIME_BASE+4, changes nothing.
- R5: The time register sits at TIME_BASE with the same low/high layout. A 4-byte write replaces only the addressed half, with the data taken from req_wdata[31:0]. An 8-byte write at TIME_BASE replaces the whole value.
- R6: After any write to the time value, every hart's interrupt line follows the new time one cycle after the register updates.
- R7: Reads return zero at offsets that map to no register, and at compare offsets that are not 4-byte aligned. Writes to such offsets change nothing.
- R8: The time value increments by one in each cycle where tick_en is high. A software write to time in the same cycle takes priority over the increment.
- R9: Reset (rst_n low, asynchronous) clears time to zero, clears irq, clears rd_data and sets every compare register to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timebase tick; time advances on cycles where this is high |
| req_valid | input | 1 | A bus access is presented this cycle |
| req_we | input | 1 | 1 for write, 0 for read |
| req_wide | input | 1 | 1 for an 8-byte access, 0 for a 4-byte access |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | 64 | Write data; 4-byte writes use bits 31:0 |
| rd_data | output | 64 | Read data, valid in the cycle after a read |
| irq | output | NHART | Per-hart timer interrupt, level |

## Verification
A behavioural reference model tracks time, the compare values, the interrupt lines and the read data, and it is compared on every cycle. The comparison is set against distinct patterns. Compare values are placed below, at and above time, which separates an unsigned "<=" from "<" or from a signed compare. Half-word writes carry garbage in the unused upper data bits, which shows whether a merge keeps the right half and takes the right lane. A time write lands in the same cycle as a tick, which exposes the priority. Time is also forced to all ones and then ticked to wrap, which exercises the interrupt lines at the extreme values. Rejected 8-byte writes at the high offsets and accesses to unmapped or misaligned offsets are each followed by read-backs, which prove that no state moved.

// File: rtl/mtc_pkg.sv
package mtc_pkg;

    // decoded target of one bus access
    typedef enum logic [2:0] {
        ACC_NONE    = 3'd0,
        ACC_TIME_LO = 3'd1,
        ACC_TIME_HI = 3'd2,
        ACC_CMP_LO  = 3'd3,
        ACC_CMP_HI  = 3'd4
    } acc_e;

    // merge write data into a 64-bit register according to half and size
    function automatic logic [63:0] merge_word(input logic [63:0] old,
                                               input logic        hi,
                                               input logic        wide,
                                               input logic [63:0] wd);
        logic [63:0] r;
        if (wide)
            r = wd;
        else if (hi)
            r = {wd[31:0], old[31:0]};
        else
            r = {old[63:32], wd[31:0]};
        return r;
    endfunction

    // view of a 64-bit register as seen by a read of one half or the whole
    function automatic logic [63:0] read_view(input logic [63:0] v,
                                              input logic        hi,
                                              input logic        wide);
        logic [63:0] r;
        if (hi)
            r = {32'd0, v[63:32]};
        else if (wide)
            r = v;
        else
            r = {32'd0, v[31:0]};
        return r;
    endfunction

endpackage

// File: rtl/mtc_decode.sv
module mtc_decode #(
    parameter int unsigned NHART     = 4,
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned CMP_BASE  = 0,
    parameter int unsigned TIME_BASE = 'h7FF8,
    localparam int unsigned HW       = (NHART > 1) ? $clog2(NHART) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output mtc_pkg::acc_e     kind,
    output logic [HW-1:0]     hart
);
    import mtc_pkg::*;

    localparam logic [31:0] CMP_SPAN = 32'(NHART * 8);
    localparam logic [31:0] T_LO     = 32'(TIME_BASE);
    localparam logic [31:0] T_HI     = 32'(TIME_BASE + 4);

    logic [31:0] a32;
    logic [31:0] rel;

    always_comb begin
        a32  = 32'(addr);
        rel  = a32 - 32'(CMP_BASE);
        kind = ACC_NONE;
        hart = rel[HW+2:3];
        if (rel < CMP_SPAN) begin
            if (rel[1:0] == 2'b00)
                kind = rel[2] ? ACC_CMP_HI : ACC_CMP_LO;
        end else if (a32 == T_LO) begin
            kind = ACC_TIME_LO;
        end else if (a32 == T_HI) begin
            kind = ACC_TIME_HI;
        end
    end

endmodule

// File: rtl/mtc_counter.sv
module mtc_counter (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        wr_en,
    input  logic        wr_hi,
    input  logic        wr_wide,
    input  logic [63:0] wdata,
    output logic [63:0] time_q
);
    import mtc_pkg::*;

    logic [63:0] time_d;

    // software write wins over the tick increment
    always_comb begin
        time_d = time_q;
        if (wr_en)
            time_d = merge_word(time_q, wr_hi, wr_wide, wdata);
        else if (tick)
            time_d = time_q + 64'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            time_q <= '0;
        else
            time_q <= time_d;
    end

endmodule

// File: rtl/mtc_cmp_bank.sv
module mtc_cmp_bank #(
    parameter int unsigned NHART = 4,
    localparam int unsigned HW   = (NHART > 1) ? $clog2(NHART) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [HW-1:0]      wr_hart,
    input  logic               wr_hi,
    input  logic               wr_wide,
    input  logic [63:0]        wdata,
    input  logic [63:0]        time_q,
    output logic [NHART*64-1:0] cmp_flat,
    output logic [NHART-1:0]   irq
);
    import mtc_pkg::*;

    for (genvar g = 0; g < NHART; g++) begin : g_hart
        logic [63:0] cmp_q;
        logic        irq_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cmp_q <= '1;
            else if (wr_en && (wr_hart == HW'(g)))
                cmp_q <= merge_word(cmp_q, wr_hi, wr_wide, wdata);
        end

        // continuous unsigned comparison, registered onto the output
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                irq_q <= 1'b0;
            else
                irq_q <= (cmp_q <= time_q);
        end

        assign cmp_flat[g*64 +: 64] = cmp_q;
        assign irq[g]               = irq_q;
    end

endmodule

// File: rtl/mtimer_cmp.sv
module mtimer_cmp #(
    parameter int unsigned NHART     = 4,
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned CMP_BASE  = 0,
    parameter int unsigned TIME_BASE = 'h7FF8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic              req_wide,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [63:0]       req_wdata,
    output logic [63:0]       rd_data,
    output logic [NHART-1:0]  irq
);
    import mtc_pkg::*;

    localparam int unsigned HW = (NHART > 1) ? $clog2(NHART) : 1;

    acc_e                kind;
    logic [HW-1:0]       hart;
    logic                is_hi;
    logic                wr_ok;
    logic                time_wr;
    logic                cmp_wr;
    logic [63:0]         time_q;
    logic [NHART*64-1:0] cmp_flat;
    logic [63:0]         cmp_sel;
    logic [63:0]         rd_val;
    logic [63:0]         rd_q;

    mtc_decode #(
        .NHART(NHART), .ADDR_W(ADDR_W),
        .CMP_BASE(CMP_BASE), .TIME_BASE(TIME_BASE)
    ) u_dec (
        .addr (req_addr),
        .kind (kind),
        .hart (hart)
    );

    assign is_hi   = (kind == ACC_TIME_HI) || (kind == ACC_CMP_HI);
    // an 8-byte write at a high-word offset is rejected
    assign wr_ok   = req_valid && req_we && !(is_hi && req_wide);
    assign time_wr = wr_ok && ((kind == ACC_TIME_LO) || (kind == ACC_TIME_HI));
    assign cmp_wr  = wr_ok && ((kind == ACC_CMP_LO) || (kind == ACC_CMP_HI));

    mtc_counter u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_en),
        .wr_en   (time_wr),
        .wr_hi   (is_hi),
        .wr_wide (req_wide),
        .wdata   (req_wdata),
        .time_q  (time_q)
    );

    mtc_cmp_bank #(.NHART(NHART)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cmp_wr),
        .wr_hart  (hart),
        .wr_hi    (is_hi),
        .wr_wide  (req_wide),
        .wdata    (req_wdata),
        .time_q   (time_q),
        .cmp_flat (cmp_flat),
        .irq      (irq)
    );

    always_comb begin
        cmp_sel = '0;
        for (int i = 0; i < NHART; i++) begin
            if (hart == HW'(i))
                cmp_sel = cmp_flat[i*64 +: 64];
        end
    end

    always_comb begin
        unique case (kind)
            ACC_TIME_LO, ACC_TIME_HI: rd_val = read_view(time_q, is_hi, req_wide);
            ACC_CMP_LO, ACC_CMP_HI:   rd_val = read_view(cmp_sel, is_hi, req_wide);
            default:                  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_q <= '0;
        else
            rd_q <= (req_valid && !req_we) ? rd_val : '0;
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/mtc_checker.sv
module mtc_checker #(
    parameter int unsigned NHART     = 4,
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned TIME_BASE = 'h7FF8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick_en,
    input logic                req_valid,
    input logic                req_we,
    input logic                req_wide,
    input logic [ADDR_W-1:0]   req_addr,
    input logic [63:0]         time_q,
    input logic [NHART*64-1:0] cmp_flat,
    input logic [NHART-1:0]    irq
);
    localparam logic [ADDR_W-1:0] TB_LO = ADDR_W'(TIME_BASE);
    localparam logic [ADDR_W-1:0] TB_HI = ADDR_W'(TIME_BASE + 4);

    logic tw_good;
    logic tw_bad;

    assign tw_good = req_valid && req_we &&
                     ((req_addr == TB_LO) || ((req_addr == TB_HI) && !req_wide));
    assign tw_bad  = req_valid && req_we && (req_addr == TB_HI) && req_wide;

    // R9: while reset is held, time and interrupts are cleared
    a_r9_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (time_q == 64'd0 && irq == '0));

    // R8: a tick with no time write advances time by one
    a_r8_tick_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !tw_good) |=> (time_q == $past(time_q) + 64'd1));

    // R8: without tick or write, time holds
    a_r8_time_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !tw_good) |=> $stable(time_q));

    // R4: a wide write at the time high offset leaves time alone
    a_r4_wide_hi_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (tw_bad && !tick_en) |=> $stable(time_q));

    // R2: each interrupt follows the unsigned comparison one cycle later
    for (genvar g = 0; g < NHART; g++) begin : g_chk
        a_r2_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
            irq[g] == ($past(cmp_flat[g*64 +: 64]) <= $past(time_q)));
    end

endmodule

bind mtimer_cmp mtc_checker #(
    .NHART(NHART), .ADDR_W(ADDR_W), .TIME_BASE(TIME_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .req_valid (req_valid),
    .req_we    (req_we),
    .req_wide  (req_wide),
    .req_addr  (req_addr),
    .time_q    (time_q),
    .cmp_flat  (cmp_flat),
    .irq       (irq)
);

// File: tb/sim_mtimer_cmp.sv
`timescale 1ns/1ps
module sim_mtimer_cmp;
    localparam int NH = 4;
    localparam int AW = 16;
    localparam int TB = 'h7FF8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          tick_en;
    logic          req_valid;
    logic          req_we;
    logic          req_wide;
    logic [AW-1:0] req_addr;
    logic [63:0]   req_wdata;
    logic [63:0]   rd_data;
    logic [NH-1:0] irq;

    int checks = 0;
    int errors = 0;
    bit started = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mtimer_cmp u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .req_valid(req_valid), .req_we(req_we), .req_wide(req_wide),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_data(rd_data), .irq(irq)
    );

    // behavioural reference model
    logic [63:0]   tm;
    logic [63:0]   nt;
    logic [63:0]   cm [NH];
    logic [NH-1:0] im;
    logic [63:0]   rm;

    function automatic logic [63:0] m_read(int a, bit w);
        if (a < NH*8) begin
            if (a % 4 != 0) return 64'd0;
            if (a % 8 == 4) return {32'd0, cm[a/8][63:32]};
            return w ? cm[a/8] : {32'd0, cm[a/8][31:0]};
        end
        if (a == TB)     return w ? tm : {32'd0, tm[31:0]};
        if (a == TB + 4) return {32'd0, tm[63:32]};
        return 64'd0;
    endfunction

    task automatic m_write(int a, bit w, logic [63:0] d);
        if (a < NH*8) begin
            if (a % 4 == 0) begin
                if (a % 8 == 4) begin
                    if (!w) cm[a/8][63:32] = d[31:0];
                end else if (w) cm[a/8] = d;
                else cm[a/8][31:0] = d[31:0];
            end
        end else if (a == TB) begin
            nt = w ? d : {tm[63:32], d[31:0]};
        end else if (a == TB + 4) begin
            if (!w) nt = {d[31:0], tm[31:0]};
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tm = '0;
            for (int i = 0; i < NH; i++) cm[i] = '1;
            im = '0;
            rm = '0;
        end else begin
            for (int i = 0; i < NH; i++) im[i] = (cm[i] <= tm);
            rm = (req_valid && !req_we) ? m_read(int'(req_addr), req_wide) : 64'd0;
            nt = tick_en ? tm + 64'd1 : tm;
            if (req_valid && req_we) m_write(int'(req_addr), req_wide, req_wdata);
            tm = nt;
        end
    end

    task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (started && rst_n && !done) begin
            chk("R2 irq vs model", 64'(irq), 64'(im));
            chk("R1 rd_data vs model", rd_data, rm);
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(int a, bit w, logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b1; req_wide = w;
        req_addr = AW'(a); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0;
    endtask

    task automatic bus_rd(int a, bit w, output logic [63:0] v);
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b0; req_wide = w;
        req_addr = AW'(a);
        @(negedge clk);
        req_valid = 1'b0;
        v = rd_data;
    endtask

    task automatic expect_rd(string tag, int a, bit w, logic [63:0] exp);
        logic [63:0] v;
        bus_rd(a, w, v);
        chk(tag, v, exp);
    endtask

    task automatic tick_for(int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; tick_en = 1'b0; req_valid = 1'b0; req_we = 1'b0;
        req_wide = 1'b0; req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        started = 1'b1;

        // R9 reset state
        chk("R9 irq after reset", 64'(irq), 64'd0);
        chk("R9 rd_data after reset", rd_data, 64'd0);
        expect_rd("R9 time after reset", TB, 1, 64'd0);
        expect_rd("R9 cmp3 after reset", 24, 1, '1);

        // R5 full time write
        bus_wr(TB, 1, 64'd100);
        expect_rd("R5 time low read", TB, 0, 64'd100);

        // R3 low-half compare write keeps high half, uses lane 31:0
        bus_wr(0, 0, 64'hDEAD_BEEF_0000_0032);
        expect_rd("R3 cmp0 after low write", 0, 1, 64'hFFFF_FFFF_0000_0032);
        idle(2);
        chk("R2 irq0 with cmp above time", 64'(irq[0]), 64'd0);
        bus_wr(4, 0, 64'hABCD_0000_0000_0000);
        idle(2);
        chk("R2 irq0 with cmp below time", 64'(irq[0]), 64'd1);
        expect_rd("R1 cmp0 high read", 4, 0, 64'd0);
        expect_rd("R1 cmp0 low read", 0, 0, 64'd50);
        expect_rd("R1 cmp0 high read wide", 4, 1, 64'd0);

        // R2 equality boundary
        bus_wr(8, 1, 64'd120);
        bus_wr(TB, 1, 64'd119);
        idle(2);
        chk("R2 irq1 one below", 64'(irq[1]), 64'd0);
        bus_wr(TB, 1, 64'd120);
        idle(2);
        chk("R2 irq1 at equality", 64'(irq[1]), 64'd1);

        // R6 time low write drops every hart
        bus_wr(TB, 0, 64'h1111_1111_0000_0000);
        idle(2);
        chk("R6 irq after time low write", 64'(irq), 64'd0);
        bus_wr(TB + 4, 0, 64'h0000_0000_FFFF_FFFF);
        idle(2);
        chk("R6 irq after time high write", 64'(irq), 64'b0011);
        expect_rd("R5 time after high write", TB, 1, 64'hFFFF_FFFF_0000_0000);

        // R4 wide writes at high offsets rejected
        bus_wr(TB + 4, 1, 64'd5);
        expect_rd("R4 time unchanged", TB, 1, 64'hFFFF_FFFF_0000_0000);
        bus_wr(20, 1, 64'd7);
        expect_rd("R4 cmp2 unchanged", 16, 1, '1);

        // R7 unmapped and misaligned
        expect_rd("R7 unmapped read", 'h100, 1, 64'd0);
        expect_rd("R7 misaligned cmp read", 2, 0, 64'd0);
        bus_wr('h100, 1, 64'd0);
        bus_wr(2, 0, 64'd0);
        expect_rd("R7 time after stray write", TB, 1, 64'hFFFF_FFFF_0000_0000);
        expect_rd("R7 cmp0 after stray write", 0, 1, 64'd50);

        // R8 write beats tick, then counting
        @(negedge clk);
        tick_en = 1'b1;
        req_valid = 1'b1; req_we = 1'b1; req_wide = 1'b1;
        req_addr = AW'(TB); req_wdata = 64'd1000;
        @(negedge clk);
        tick_en = 1'b0; req_valid = 1'b0; req_we = 1'b0;
        expect_rd("R8 write wins over tick", TB, 1, 64'd1000);
        tick_for(5);
        expect_rd("R8 five ticks", TB, 1, 64'd1005);

        // R2 extremes: all ones, then wrap to zero
        bus_wr(TB, 1, '1);
        idle(2);
        chk("R2 irq at time all ones", 64'(irq), 64'b1111);
        tick_for(1);
        idle(2);
        chk("R2 irq after wrap", 64'(irq), 64'd0);
        expect_rd("R8 wrap to zero", TB, 1, 64'd0);

        // free-running ticks checked cycle by cycle against the model
        tick_for(200);
        idle(3);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule